// File: doc/BRIEF.md
# DAC Sweep Characterization Controller

This block is the outer loop of a current-voltage characterization run on one crossbar cell. On a start strobe it either launches a single operation at a static DAC code, or, when auto-sweep is enabled, walks the active DAC code from a first value toward a last value in fixed increments. At each code it issues one start strobe to the single-operation cell sequencer. It then waits for that sequencer's done pulse before it moves to the next code, so the ADC reading of each point can be collected between iterations.

The sweep bounds and the increment are sampled when the start strobe is accepted. Later changes to them do not affect a sweep already in progress. An abort strobe or a compliance trip reported by the sequencer ends the run at once. A zero increment, or a next code that would pass the last value or leave the 8-bit range, ends the run after the current point.

Top module: `sweep_ctrl`

## Requirements
- R1: After reset the controller is idle: `sweep_busy`=0, `seq_start`=0 and `dac_code`=0x00.
- R2: A `go` pulse with `sweep_en`=0 gives exactly one `seq_start` pulse, with `dac_code` equal to `static_code`. The controller returns to idle on the following `seq_done`.
- R3: A `go` pulse with `sweep_en`=1 gives a first point at `cfg_first`. Each later point's code is the previous code plus `cfg_incr`. A new `seq_start` is issued only after `seq_done` for the previous point.
- R4: After a point at code c, the sweep ends on that point's `seq_done` if c+`cfg_incr` (computed to 9 bits) is greater than `cfg_last` or greater than 255. With `cfg_first` greater than `cfg_last`, the run is therefore one point.
- R5: With `cfg_incr`=0 and `sweep_en`=1, the run is a single point at `cfg_first`.
- R6: `abort` high while busy returns the controller to idle on the next clock. No further `seq_start` follows, and a `seq_start` in the same cycle as `abort` is suppressed.
- R7: `seq_trip` high while the controller waits for a point returns it to idle on the next clock, with no further `seq_start`.
- R8: A `go` pulse while busy is ignored. Changes to `cfg_first`, `cfg_last`, `cfg_incr` or `static_code` after the run is accepted do not change the codes of that run.
- R9: `seq_start` is high for one clock per point. `dac_code` is valid when `seq_start` is high and stays unchanged while the controller waits for that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe for a run |
| abort | input | 1 | Ends the current run immediately |
| sweep_en | input | 1 | 1: sweep run, 0: single operation at the static code |
| cfg_first | input | 8 | First code of a sweep |
| cfg_last | input | 8 | Upper limit of a sweep |
| cfg_incr | input | 8 | Code increment between sweep points |
| static_code | input | 8 | Code used for a single operation |
| seq_done | input | 1 | Sequencer finished the current point |
| seq_trip | input | 1 | Sequencer reports a compliance trip |
| dac_code | output | 8 | Active DAC code |
| seq_start | output | 1 | Per-point start strobe to the sequencer |
| sweep_busy | output | 1 | Run in progress |

## Verification
The embedded assertions check on every cycle that the strobe lasts one clock and occurs only while busy. They also check that the code holds steady while a point is outstanding, and that abort or a trip drops the busy flag on the next clock. The code sequence itself, the stopping point at the last value or at 8-bit overflow, the zero-increment case and the insensitivity to mid-run configuration changes can only be shown by the bench. It runs a grid of first/last/increment values against an arithmetic model, and uses a responder that plays the sequencer, including trip and abort injection.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    parameter int CODE_W = 8;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_LAUNCH = 2'd1,
        SW_WAIT   = 2'd2
    } sw_state_e;

    typedef struct packed {
        sw_state_e         state;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] last;
        logic [CODE_W-1:0] incr;
        logic              multi;
    } sw_regs_t;
endpackage

// File: rtl/sweep_step_calc.sv
module sweep_step_calc
    import sweep_pkg::*;
(
    input  logic [CODE_W-1:0] cur_code,
    input  logic [CODE_W-1:0] incr,
    input  logic [CODE_W-1:0] last_code,
    output logic [CODE_W-1:0] next_code,
    output logic              final_pt
);
    localparam int SUM_W = CODE_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum       = {1'b0, cur_code} + {1'b0, incr};
        next_code = sum[CODE_W-1:0];
        final_pt  = (incr == '0) || sum[CODE_W] || (sum[CODE_W-1:0] > last_code);
    end
endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic              sweep_en,
    input  logic [CODE_W-1:0] cfg_first,
    input  logic [CODE_W-1:0] cfg_last,
    input  logic [CODE_W-1:0] cfg_incr,
    input  logic [CODE_W-1:0] static_code,
    input  logic              seq_done,
    input  logic              seq_trip,
    input  logic [CODE_W-1:0] next_code,
    input  logic              final_pt,
    output logic [CODE_W-1:0] code_q,
    output logic [CODE_W-1:0] last_q,
    output logic [CODE_W-1:0] incr_q,
    output logic              seq_start,
    output logic              busy
);
    sw_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SW_IDLE: begin
                if (go) begin
                    r_d.state = SW_LAUNCH;
                    r_d.multi = sweep_en;
                    r_d.last  = cfg_last;
                    r_d.incr  = cfg_incr;
                    r_d.code  = sweep_en ? cfg_first : static_code;
                end
            end
            SW_LAUNCH: begin
                r_d.state = abort ? SW_IDLE : SW_WAIT;
            end
            SW_WAIT: begin
                if (abort || seq_trip) begin
                    r_d.state = SW_IDLE;
                end else if (seq_done) begin
                    if (!r_q.multi || final_pt) begin
                        r_d.state = SW_IDLE;
                    end else begin
                        r_d.state = SW_LAUNCH;
                        r_d.code  = next_code;
                    end
                end
            end
            default: r_d.state = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SW_IDLE, code: '0, last: '0, incr: '0, multi: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign code_q    = r_q.code;
    assign last_q    = r_q.last;
    assign incr_q    = r_q.incr;
    assign seq_start = (r_q.state == SW_LAUNCH) && !abort;
    assign busy      = (r_q.state != SW_IDLE);

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    // R9
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy);

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_start && !seq_done) |=> $stable(code_q));

    // R6
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy) |=> !busy);

    // R7
    trip_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_trip && busy && !seq_start) |=> !busy);
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import sweep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic              sweep_en,
    input  logic [CODE_W-1:0] cfg_first,
    input  logic [CODE_W-1:0] cfg_last,
    input  logic [CODE_W-1:0] cfg_incr,
    input  logic [CODE_W-1:0] static_code,
    input  logic              seq_done,
    input  logic              seq_trip,
    output logic [CODE_W-1:0] dac_code,
    output logic              seq_start,
    output logic              sweep_busy
);
    logic [CODE_W-1:0] code_w, last_w, incr_w, next_w;
    logic              final_w;

    sweep_step_calc u_calc (
        .cur_code  (code_w),
        .incr      (incr_w),
        .last_code (last_w),
        .next_code (next_w),
        .final_pt  (final_w)
    );

    sweep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .abort       (abort),
        .sweep_en    (sweep_en),
        .cfg_first   (cfg_first),
        .cfg_last    (cfg_last),
        .cfg_incr    (cfg_incr),
        .static_code (static_code),
        .seq_done    (seq_done),
        .seq_trip    (seq_trip),
        .next_code   (next_w),
        .final_pt    (final_w),
        .code_q      (code_w),
        .last_q      (last_w),
        .incr_q      (incr_w),
        .seq_start   (seq_start),
        .busy        (sweep_busy)
    );

    assign dac_code = code_w;
endmodule

// File: tb/sweep_ctrl_test.sv
`timescale 1ns/1ps
module sweep_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0, abort = 1'b0, sweep_en = 1'b0;
    logic [7:0] cfg_first = 8'h00, cfg_last = 8'hFF, cfg_incr = 8'h10, static_code = 8'h00;
    logic       seq_done = 1'b0, seq_trip = 1'b0;
    logic [7:0] dac_code;
    logic       seq_start, sweep_busy;

    int n_checks = 0;
    int n_fail   = 0;
    int got_n    = 0;
    int trip_at  = 0;
    int dly      = 0;
    logic [7:0] got [0:299];

    always #2.5 clk = ~clk;

    sweep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .sweep_en(sweep_en),
        .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_incr(cfg_incr),
        .static_code(static_code), .seq_done(seq_done), .seq_trip(seq_trip),
        .dac_code(dac_code), .seq_start(seq_start), .sweep_busy(sweep_busy)
    );

    // Sequencer stand-in: records each strobe, replies with done or trip.
    always @(negedge clk) begin
        seq_done = 1'b0;
        seq_trip = 1'b0;
        if (dly > 0) begin
            dly = dly - 1;
            if (dly == 0) begin
                if (trip_at == got_n) seq_trip = 1'b1;
                else seq_done = 1'b1;
            end
        end
        if (seq_start) begin
            if (got_n < 300) got[got_n] = dac_code;
            got_n = got_n + 1;
            dly = 3;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((sweep_busy || dly != 0) && t < 5000) begin
            @(negedge clk); t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_run(input string req, input logic [7:0] first,
                               input logic [7:0] inc, input int n_exp);
        int bad = -1;
        check(got_n == n_exp, req, got_n, n_exp);
        for (int i = 0; i < n_exp && i < got_n && i < 300; i++) begin
            if (bad < 0 && got[i] != 8'((int'(first) + i * int'(inc)) & 255)) bad = i;
        end
        if (bad >= 0)
            check(1'b0, req, got[bad], (int'(first) + bad * int'(inc)) & 255);
        else
            check(1'b1, req, 0, 0);
    endtask

    task automatic sweep_case(input logic [7:0] s, input logic [7:0] e, input logic [7:0] st);
        int n = 1;
        int c = s;
        string req;
        while (st != 0 && c + st <= e && c + st <= 255) begin
            c = c + st; n++;
        end
        req = (st == 0) ? "R5" : ((n == 1) ? "R4" : "R3");
        got_n = 0; trip_at = 0;
        sweep_en = 1'b1; cfg_first = s; cfg_last = e; cfg_incr = st;
        pulse_go();
        wait_idle();
        compare_run(req, s, st, n);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] starts [0:3];
        logic [7:0] ends   [0:2];
        logic [7:0] steps  [0:3];
        starts = '{8'h00, 8'h10, 8'h37, 8'hF0};
        ends   = '{8'h00, 8'h80, 8'hFF};
        steps  = '{8'h00, 8'h01, 8'h10, 8'h55};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(!sweep_busy && !seq_start && dac_code == 8'h00, "R1",
              {sweep_busy, seq_start, dac_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sweep_busy && !seq_start && dac_code == 8'h00, "R1",
              {sweep_busy, seq_start, dac_code}, 0);

        // R2: single operation at the static code
        got_n = 0; sweep_en = 1'b0; static_code = 8'h5A; cfg_first = 8'h11;
        pulse_go();
        wait_idle();
        check(got_n == 1, "R2", got_n, 1);
        check(got[0] == 8'h5A, "R2", got[0], 8'h5A);

        // R3 R4 R5: grid of sweep settings
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
                for (int k = 0; k < 4; k++)
                    sweep_case(starts[a], ends[b], steps[k]);

        // R4: overflow past 8 bits stops the sweep
        sweep_case(8'hC0, 8'hFF, 8'h30);

        // R8: go and config changes mid-run are ignored
        got_n = 0; trip_at = 0;
        sweep_en = 1'b1; cfg_first = 8'h00; cfg_last = 8'h30; cfg_incr = 8'h10;
        pulse_go();
        while (got_n < 2) @(negedge clk);
        go = 1'b1; cfg_first = 8'h80; cfg_last = 8'h10; cfg_incr = 8'h01;
        @(negedge clk); go = 1'b0;
        wait_idle();
        compare_run("R8", 8'h00, 8'h10, 4);

        // R6: abort in the middle of a sweep
        got_n = 0; trip_at = 0;
        cfg_first = 8'h00; cfg_last = 8'hFF; cfg_incr = 8'h10;
        pulse_go();
        while (got_n < 2) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check(!sweep_busy, "R6", sweep_busy, 0);
        repeat (20) @(negedge clk);
        check(got_n == 2, "R6", got_n, 2);
        dly = 0;

        // R6: abort in the launch cycle suppresses the strobe
        got_n = 0;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0; abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        repeat (10) @(negedge clk);
        check(got_n == 0 && !sweep_busy, "R6", got_n, 0);

        // R7: compliance trip on the third point
        got_n = 0; trip_at = 3;
        pulse_go();
        wait_idle();
        compare_run("R7", 8'h00, 8'h10, 3);
        trip_at = 0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule